// File: doc/BRIEF.md
# Pulse-Aligned Seconds/Ticks Timekeeper

This block keeps absolute time as a 64-bit value made of a 32-bit seconds count in the upper half and a 32-bit ticks count in the lower half. The ticks count advances on every clock. When it reaches the last tick of a second, it returns to zero and the seconds count goes up by one.

Software sets the time through a write-only register port. It first writes the seconds and ticks values it wants. These are only staged: the running time does not change until a commit. A commit happens in one of two ways:
- A write of 1 to the immediate register loads the staged time on that clock edge.
- Writing the ticks register arms the block. The staged time then loads on the next chosen edge of a once-per-second pulse.

A flags register picks which edge of that pulse counts and which of two pulse inputs is used. Each time the chosen edge arrives, the block emits a one-cycle pulse-seen output, whether or not it loads anything.

Top module: `pps_timekeeper`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `time_now` is zero and `pps_seen` is 0. The flags and the immediate mode reset to 0, and the block is not armed.
- R2: Writes decode at word addresses BASE_ADDR+0 (staged seconds), +1 (staged ticks), +2 (flags) and +3 (immediate). A write to any other address changes nothing.
- R3: Writing the staged seconds or ticks does not change `time_now`. The time keeps counting normally.
- R4: With no commit, the ticks count rises by one each cycle. When ticks is at or above TICKS_PER_SEC-1, ticks returns to 0 and seconds rises by one. Seconds wraps modulo 2^32.
- R5: A write to +3 with data bit 0 = 1 loads the staged time on that edge, taking the place of the increment. `time_now` equals the staged value in the following cycle. A write to +3 with bit 0 = 0 loads nothing.
- R6: When the block is armed and immediate mode is 0, the chosen pulse edge loads the staged time. The loaded value appears in the same cycle that `pps_seen` is high.
- R7: Flags bit 0 chooses the edge: 0 means falling and 1 means rising. The other edge neither pulses `pps_seen` nor loads.
- R8: Flags bit 1 chooses the input: 0 is `pps_ext` and 1 is `pps_mate`. The input that is not chosen is ignored.
- R9: The chosen input passes through two synchronizer flops. `pps_seen` goes high for exactly one cycle, in the third cycle after the input changes.
- R10: A commit clears the armed state. Later pulse edges only raise `pps_seen` until the ticks register is written again.
- R11: Immediate mode, which is bit 0 of the last value written to +3, blocks pulse loads while it is 1. The armed state is kept, so a later pulse loads once the mode is written back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register word address |
| wr_data | input | 32 | Register write data |
| pps_ext | input | 1 | Pulse input from the external connector (asynchronous) |
| pps_mate | input | 1 | Pulse input from the neighbouring board (asynchronous) |
| time_now | output | 64 | Current time: seconds in [63:32], ticks in [31:0] |
| pps_seen | output | 1 | One-cycle pulse on each chosen edge of the chosen input |

## Verification
The bench goes after the rollover cases:
- A staged ticks value that is already past the limit: a design comparing for equality would run on through 2^32 ticks.
- Seconds wrapping from all ones: a design that saturated would stop there.

On the pulse side, the bench drives the wrong edge and the unchosen input. A design that mixed these up would load early, or would raise `pps_seen` on every transition. The bench then repeats an edge with no new ticks write; a block that did not clear its armed state would jump back to the old staged time. It also checks that immediate mode holds off a pulse load but does not disarm. A design that ignored the mode would load at once, and one that disarmed would never load after the mode returns to 0.

// File: rtl/tk_pkg.sv
package tk_pkg;

  // Word offsets of the control registers from the block base address.
  localparam int unsigned OFS_SECS  = 0;
  localparam int unsigned OFS_TICKS = 1;
  localparam int unsigned OFS_FLAGS = 2;
  localparam int unsigned OFS_IMM   = 3;
  localparam int unsigned NUM_REGS  = 4;

  // Bit positions inside the flags and immediate registers.
  localparam int unsigned FLAG_EDGE_BIT = 0;
  localparam int unsigned FLAG_SRC_BIT  = 1;
  localparam int unsigned IMM_BIT       = 0;

  typedef struct packed {
    logic from_mate;  // 1: board-to-board input, 0: external connector
    logic on_rise;    // 1: rising edge, 0: falling edge
  } pps_cfg_t;

endpackage

// File: rtl/tk_regs.sv
module tk_regs
  import tk_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BASE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pps_hit,
  output logic [DATA_W-1:0] pend_secs,
  output logic [DATA_W-1:0] pend_ticks,
  output pps_cfg_t          cfg,
  output logic              imm_mode,
  output logic              armed,
  output logic              tick_wr,
  output logic              pps_fire,
  output logic              commit
);

  logic [NUM_REGS-1:0] sel;
  logic                imm_fire;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      sel[i] = wr_en && (wr_addr == ADDR_W'(BASE_ADDR + i));
    end
  end

  assign tick_wr  = sel[OFS_TICKS];
  assign imm_fire = sel[OFS_IMM] && wr_data[IMM_BIT];
  assign pps_fire = pps_hit && armed && !imm_mode;
  assign commit   = imm_fire || pps_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_secs  <= '0;
      pend_ticks <= '0;
      cfg        <= '0;
      imm_mode   <= 1'b0;
      armed      <= 1'b0;
    end else begin
      if (sel[OFS_SECS])  pend_secs  <= wr_data;
      if (sel[OFS_TICKS]) pend_ticks <= wr_data;
      if (sel[OFS_FLAGS]) begin
        cfg.on_rise   <= wr_data[FLAG_EDGE_BIT];
        cfg.from_mate <= wr_data[FLAG_SRC_BIT];
      end
      if (sel[OFS_IMM]) imm_mode <= wr_data[IMM_BIT];
      // A new ticks value re-arms; otherwise any commit disarms.
      if (tick_wr)     armed <= 1'b1;
      else if (commit) armed <= 1'b0;
    end
  end

endmodule

// File: rtl/tk_pps_detect.sv
module tk_pps_detect
  import tk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  pps_cfg_t cfg,
  input  logic     pps_ext,
  input  logic     pps_mate,
  output logic     hit,
  output logic     pulse
);

  localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

  logic               picked;
  logic [CHAIN_W-1:0] chain;
  logic               now_lvl;
  logic               old_lvl;

  assign picked = cfg.from_mate ? pps_mate : pps_ext;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[CHAIN_W-2:0], picked};
  end

  assign now_lvl = chain[SYNC_STAGES-1];
  assign old_lvl = chain[SYNC_STAGES];
  assign hit     = cfg.on_rise ? (now_lvl && !old_lvl) : (!now_lvl && old_lvl);

  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= hit;
  end

endmodule

// File: rtl/tk_counter.sv
module tk_counter #(
  parameter int unsigned TICKS_PER_SEC = 100_000_000,
  parameter int unsigned TIME_W        = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [TIME_W-1:0] load_secs,
  input  logic [TIME_W-1:0] load_ticks,
  output logic [TIME_W-1:0] secs,
  output logic [TIME_W-1:0] ticks
);

  localparam logic [TIME_W-1:0] LAST_TICK = TIME_W'(TICKS_PER_SEC - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      secs  <= '0;
      ticks <= '0;
    end else if (load) begin
      secs  <= load_secs;
      ticks <= load_ticks;
    end else if (ticks >= LAST_TICK) begin
      secs  <= secs + 1'b1;
      ticks <= '0;
    end else begin
      ticks <= ticks + 1'b1;
    end
  end

endmodule

// File: rtl/pps_timekeeper.sv
module pps_timekeeper
  import tk_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 100_000_000,
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned BASE_ADDR     = 0,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              pps_ext,
  input  logic              pps_mate,
  output logic [63:0]       time_now,
  output logic              pps_seen
);

  localparam int unsigned HALF_W = 32;

  pps_cfg_t          cfg;
  logic [HALF_W-1:0] pend_secs;
  logic [HALF_W-1:0] pend_ticks;
  logic [HALF_W-1:0] cur_secs;
  logic [HALF_W-1:0] cur_ticks;
  logic              imm_mode;
  logic              armed;
  logic              tick_wr;
  logic              pps_fire;
  logic              commit;
  logic              pps_hit;

  tk_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (HALF_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pps_hit   (pps_hit),
    .pend_secs (pend_secs),
    .pend_ticks(pend_ticks),
    .cfg       (cfg),
    .imm_mode  (imm_mode),
    .armed     (armed),
    .tick_wr   (tick_wr),
    .pps_fire  (pps_fire),
    .commit    (commit)
  );

  tk_pps_detect #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_pps (
    .clk     (clk),
    .rst     (rst),
    .cfg     (cfg),
    .pps_ext (pps_ext),
    .pps_mate(pps_mate),
    .hit     (pps_hit),
    .pulse   (pps_seen)
  );

  tk_counter #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .TIME_W       (HALF_W)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load      (commit),
    .load_secs (pend_secs),
    .load_ticks(pend_ticks),
    .secs      (cur_secs),
    .ticks     (cur_ticks)
  );

  assign time_now = {cur_secs, cur_ticks};

endmodule

// File: rtl/tk_checker.sv
module tk_checker #(
  parameter int unsigned TICKS_PER_SEC = 100_000_000,
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned BASE_ADDR     = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [63:0]       time_now,
  input logic              pps_seen,
  input logic [31:0]       pend_secs,
  input logic [31:0]       pend_ticks,
  input logic              armed,
  input logic              tick_wr,
  input logic              pps_fire,
  input logic              commit
);

  localparam logic [31:0] LAST_TICK = 32'(TICKS_PER_SEC - 1);
  localparam logic [ADDR_W-1:0] IMM_ADDR = ADDR_W'(BASE_ADDR + 3);

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (time_now == 64'd0 && !pps_seen));

  // R5
  p_imm_load_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == IMM_ADDR && wr_data[0])
      |=> time_now == {$past(pend_secs), $past(pend_ticks)});

  // R4
  p_tick_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!commit && time_now[31:0] < LAST_TICK)
      |=> (time_now[31:0] == $past(time_now[31:0]) + 32'd1 &&
           time_now[63:32] == $past(time_now[63:32])));

  // R4
  p_rollover_r4: assert property (@(posedge clk) disable iff (rst)
    (!commit && time_now[31:0] >= LAST_TICK)
      |=> (time_now[31:0] == 32'd0 &&
           time_now[63:32] == $past(time_now[63:32]) + 32'd1));

  // R6
  p_pps_load_r6: assert property (@(posedge clk) disable iff (rst)
    pps_fire |=> (pps_seen && time_now == {$past(pend_secs), $past(pend_ticks)}));

  // R10
  p_disarm_r10: assert property (@(posedge clk) disable iff (rst)
    (commit && !tick_wr) |=> !armed);

endmodule

bind pps_timekeeper tk_checker #(
  .TICKS_PER_SEC(TICKS_PER_SEC),
  .ADDR_W       (ADDR_W),
  .BASE_ADDR    (BASE_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .time_now  (time_now),
  .pps_seen  (pps_seen),
  .pend_secs (pend_secs),
  .pend_ticks(pend_ticks),
  .armed     (armed),
  .tick_wr   (tick_wr),
  .pps_fire  (pps_fire),
  .commit    (commit)
);

// File: tb/pps_timekeeper_test.sv
module pps_timekeeper_test;

  localparam int unsigned TPS    = 10;
  localparam int unsigned ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic              pps_ext = 1'b0;
  logic              pps_mate = 1'b0;
  logic [63:0]       time_now;
  logic              pps_seen;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  pps_timekeeper #(
    .TICKS_PER_SEC(TPS),
    .ADDR_W       (ADDR_W),
    .BASE_ADDR    (0),
    .SYNC_STAGES  (2)
  ) uut (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pps_ext (pps_ext),
    .pps_mate(pps_mate),
    .time_now(time_now),
    .pps_seen(pps_seen)
  );

  typedef struct packed {
    logic [31:0] secs;
    logic [31:0] ticks;
    logic [31:0] wait_n;
    logic [31:0] exp_secs;
    logic [31:0] exp_ticks;
  } vec_t;

  // Immediate loads followed by free counting (ticks limit 10).
  localparam vec_t VEC [5] = '{
    '{32'd5,          32'd0,  32'd3,  32'd5,   32'd3},
    '{32'd7,          32'd8,  32'd3,  32'd8,   32'd1},
    '{32'hFFFF_FFFF,  32'd9,  32'd1,  32'd0,   32'd0},
    '{32'd100,        32'd2,  32'd25, 32'd102, 32'd7},
    '{32'd3,          32'd12, 32'd1,  32'd4,   32'd0}
  };

  task automatic chk_time(input string req, input logic [31:0] s, input logic [31:0] t);
    n_checks++;
    if (time_now !== {s, t}) begin
      n_fails++;
      $display("FAIL %s time actual=%0d:%0d expected=%0d:%0d",
               req, time_now[63:32], time_now[31:0], s, t);
    end
  endtask

  task automatic chk_pulse(input string req, input logic exp);
    n_checks++;
    if (pps_seen !== exp) begin
      n_fails++;
      $display("FAIL %s pps_seen actual=%0b expected=%0b", req, pps_seen, exp);
    end
  endtask

  // Starts at a falling edge, ends at the next falling edge (one write edge).
  task automatic wr(input int a, input logic [31:0] d);
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(a);
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    step(2);
    chk_time("R1", 32'd0, 32'd0);
    chk_pulse("R1", 1'b0);
    rst = 1'b0;

    // Vector table: immediate load then free counting.
    foreach (VEC[i]) begin
      wr(0, VEC[i].secs);
      wr(1, VEC[i].ticks);
      wr(3, 32'd1);
      chk_time("R5", VEC[i].secs, VEC[i].ticks);
      step(int'(VEC[i].wait_n));
      chk_time("R4", VEC[i].exp_secs, VEC[i].exp_ticks);
    end

    // Known base, then immediate mode back to 0 without a load.
    wr(0, 32'd2);
    wr(1, 32'd0);
    wr(3, 32'd1);
    chk_time("R5", 32'd2, 32'd0);
    wr(3, 32'd2);
    chk_time("R5", 32'd2, 32'd1);
    wr(4, 32'd1);
    chk_time("R2", 32'd2, 32'd2);
    wr(0, 32'd50);
    wr(1, 32'd3);
    chk_time("R3", 32'd2, 32'd4);

    // Falling edge selected: rising edge on connector input ignored.
    pps_ext = 1'b1;
    step(3);
    chk_time("R7", 32'd2, 32'd7);
    chk_pulse("R7", 1'b0);
    pps_ext = 1'b0;
    step(2);
    chk_pulse("R9", 1'b0);
    chk_time("R9", 32'd2, 32'd9);
    step(1);
    chk_pulse("R6", 1'b1);
    chk_time("R6", 32'd50, 32'd3);
    step(1);
    chk_pulse("R9", 1'b0);
    chk_time("R4", 32'd50, 32'd4);

    // No re-arm: next falling edge only pulses.
    pps_ext = 1'b1;
    step(3);
    pps_ext = 1'b0;
    step(3);
    chk_pulse("R10", 1'b1);
    chk_time("R10", 32'd51, 32'd0);

    // Rising edge on the board-to-board input.
    wr(2, 32'd3);
    wr(0, 32'd900);
    wr(1, 32'd5);
    pps_ext = 1'b1;
    step(3);
    chk_pulse("R8", 1'b0);
    chk_time("R8", 32'd51, 32'd6);
    pps_mate = 1'b1;
    step(3);
    chk_pulse("R8", 1'b1);
    chk_time("R7", 32'd900, 32'd5);
    pps_mate = 1'b0;
    pps_ext  = 1'b0;
    step(3);
    chk_pulse("R7", 1'b0);
    chk_time("R7", 32'd900, 32'd8);

    // Immediate mode holds off pulse loads but keeps the armed state.
    wr(0, 32'd7);
    wr(1, 32'd4);
    chk_time("R4", 32'd901, 32'd0);
    wr(3, 32'd1);
    chk_time("R5", 32'd7, 32'd4);
    wr(1, 32'd2);
    pps_mate = 1'b1;
    step(3);
    chk_pulse("R11", 1'b1);
    chk_time("R11", 32'd7, 32'd8);
    pps_mate = 1'b0;
    step(3);
    wr(3, 32'd0);
    chk_time("R11", 32'd8, 32'd2);
    pps_mate = 1'b1;
    step(3);
    chk_pulse("R11", 1'b1);
    chk_time("R11", 32'd7, 32'd2);

    // Reset in the middle of a run.
    rst = 1'b1;
    step(1);
    chk_time("R1", 32'd0, 32'd0);
    chk_pulse("R1", 1'b0);
    rst = 1'b0;
    step(1);
    chk_time("R1", 32'd0, 32'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule